// File: doc/BRIEF.md
# Control-Pin Preset Selector

This block decides the live operating state of a single-PLL clock generator from three external select pins. The pin levels form an index into an eight-entry preset table. Each preset picks one of two programmable output-state definitions for the Y1 output and one for the Y2/Y3 pair. It also picks the PLL divider set and a spread-spectrum amount. The block registers the result and drives the Y1 and Y2/Y3 output modes, the PLL power-down, the divider-set select and the spread code with its center/down flag.

Two configuration inputs override the pins. When the upper two select pins are in use as a serial bus, they read as zero, so S0 alone chooses between presets 0 and 1. A global power-down bit forces the device into its off state and leaves the preset table untouched. The pins pass through a synchronizer before use. A one-cycle pulse marks every change of the selected divider set so that the PLL logic downstream can re-lock.

Top module: `preset_pin_selector`

## Requirements
- R1: The synchronized index {S2,S1,S0} selects preset i. The preset's fields are bit i of `y1_sel_tbl`, `fs_tbl` and `y23_sel_tbl`, and bits [3i+2:3i] of `ssc_tbl`.
- R2: A pin change shows on the outputs at the third rising clock edge after it. A change of the table, definition or flag inputs shows at the next rising edge.
- R3: A select bit of 0 applies the State0 definition (`*_def0`) and a bit of 1 applies State1 (`*_def1`). The single Y2/Y3 select bit drives both outputs. Output mode encoding: 01 high-impedance, 10 driven low, 11 enabled. Output modes never read 00.
- R4: A selected definition code of 00, for either Y1 or Y2/Y3, powers down the device: `pll_pd`=1 and both output modes read 01.
- R5: `freq_sel` equals the selected preset's frequency-select bit (0 = divider set 0, 1 = divider set 1).
- R6: `ssc_code` equals the selected 3-bit spread code. `ssc_quarters` gives the spread in units of 0.25 percent: codes 0 to 6 map to 0 to 6, and code 7 maps to 8. `ssc_center` follows `spread_center` (1 = centered, 0 = downward).
- R7: With `bus_mode`=1, S1 and S2 read as 0, so only presets 0 and 1 are reachable.
- R8: `global_pd`=1 forces `pll_pd`=1 and both modes to 01 at the next edge. When it clears, the preset in force before returns.
- R9: `freq_changed` pulses for exactly one cycle, in the cycle `freq_sel` takes a new value.
- R10: During reset the outputs are: modes 01, `pll_pd`=1, and `freq_sel`, `ssc_code`, `ssc_quarters`, `ssc_center` and `freq_changed` all 0.
- R11: The package default constants are State0 = 01, State1 = 11 and select tables 8'b0000_0010. With these defaults, S0=0 leaves the outputs high-impedance and S0=1 enables them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_pins | input | 3 | Asynchronous select pins {S2,S1,S0} |
| bus_mode | input | 1 | S1/S2 serve as the serial bus |
| global_pd | input | 1 | Global power-down override |
| y1_sel_tbl | input | 8 | Y1 state-select bit per preset |
| fs_tbl | input | 8 | Frequency-select bit per preset |
| ssc_tbl | input | 24 | 3-bit spread code per preset |
| y23_sel_tbl | input | 8 | Y2/Y3 state-select bit per preset |
| y1_def0 | input | 2 | Y1 State0 definition |
| y1_def1 | input | 2 | Y1 State1 definition |
| y23_def0 | input | 2 | Y2/Y3 State0 definition |
| y23_def1 | input | 2 | Y2/Y3 State1 definition |
| spread_center | input | 1 | Spread direction (1 = center) |
| y1_mode | output | 2 | Y1 output mode |
| y23_mode | output | 2 | Y2/Y3 output mode |
| pll_pd | output | 1 | PLL power-down |
| freq_sel | output | 1 | Divider-set select |
| ssc_code | output | 3 | Spread code |
| ssc_quarters | output | 4 | Spread amount in 0.25 % units |
| ssc_center | output | 1 | Spread direction |
| freq_changed | output | 1 | One-cycle divider-set change pulse |

## Verification
Random tables, definitions and pin levels are compared against a bench model. Those tables often contain 00 codes and differing State0/State1 pairs, which separates a wrong-definition pick from a missed power-down. Directed runs go through all eight indices with bus mode off and on, so the S1/S2 masking shows as a fold onto presets 0 and 1. A global power-down pulse followed by release shows that the stored preset comes back. Pin steps are timed so that the divider-change pulse must land in exactly the cycle the select bit flips, and must be gone one cycle later.

// File: rtl/pps_pkg.sv
package pps_pkg;
   localparam int SSC_W = 3;

   typedef enum logic [1:0] {
      DEF_PWRDN = 2'b00,
      DEF_HIZ   = 2'b01,
      DEF_LOW   = 2'b10,
      DEF_ON    = 2'b11
   } out_def_e;

   localparam logic [1:0] DFLT_DEF0   = 2'b01;
   localparam logic [1:0] DFLT_DEF1   = 2'b11;
   localparam logic [7:0] DFLT_SELTBL = 8'b0000_0010;

   function automatic logic [3:0] spread_quarters(input logic [SSC_W-1:0] code);
      return (code == 3'd7) ? 4'd8 : {1'b0, code};
   endfunction
endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pps_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d_async;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pps_preset_mux.sv
module pps_preset_mux
   import pps_pkg::*;
#(
   parameter int SEL_W = 3,
   localparam int NUM_PRESETS = 1 << SEL_W
) (
   input  logic [SEL_W-1:0]             idx,
   input  logic [NUM_PRESETS-1:0]       y1_sel_tbl,
   input  logic [NUM_PRESETS-1:0]       fs_tbl,
   input  logic [NUM_PRESETS*SSC_W-1:0] ssc_tbl,
   input  logic [NUM_PRESETS-1:0]       y23_sel_tbl,
   output logic                         y1_sel,
   output logic                         fs,
   output logic [SSC_W-1:0]             ssc,
   output logic                         y23_sel
);
   assign y1_sel  = y1_sel_tbl[idx];
   assign fs      = fs_tbl[idx];
   assign y23_sel = y23_sel_tbl[idx];
   assign ssc     = ssc_tbl[idx*SSC_W +: SSC_W];
endmodule

// File: rtl/pps_state_decode.sv
module pps_state_decode
   import pps_pkg::*;
(
   input  logic       y1_sel,
   input  logic       y23_sel,
   input  logic [1:0] y1_def0,
   input  logic [1:0] y1_def1,
   input  logic [1:0] y23_def0,
   input  logic [1:0] y23_def1,
   input  logic       global_pd,
   output logic [1:0] y1_mode,
   output logic [1:0] y23_mode,
   output logic       pll_pd
);
   logic [1:0] y1_def, y23_def;
   logic       dev_pd;

   always_comb begin
      y1_def  = y1_sel  ? y1_def1  : y1_def0;
      y23_def = y23_sel ? y23_def1 : y23_def0;
      dev_pd  = global_pd || (y1_def == DEF_PWRDN) || (y23_def == DEF_PWRDN);
      pll_pd   = dev_pd;
      y1_mode  = dev_pd ? DEF_HIZ : y1_def;
      y23_mode = dev_pd ? DEF_HIZ : y23_def;
   end
endmodule

// File: rtl/preset_pin_selector.sv
module preset_pin_selector
   import pps_pkg::*;
#(
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_PRESETS = 1 << SEL_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SEL_W-1:0]             sel_pins,
   input  logic                         bus_mode,
   input  logic                         global_pd,
   input  logic [NUM_PRESETS-1:0]       y1_sel_tbl,
   input  logic [NUM_PRESETS-1:0]       fs_tbl,
   input  logic [NUM_PRESETS*SSC_W-1:0] ssc_tbl,
   input  logic [NUM_PRESETS-1:0]       y23_sel_tbl,
   input  logic [1:0]                   y1_def0,
   input  logic [1:0]                   y1_def1,
   input  logic [1:0]                   y23_def0,
   input  logic [1:0]                   y23_def1,
   input  logic                         spread_center,
   output logic [1:0]                   y1_mode,
   output logic [1:0]                   y23_mode,
   output logic                         pll_pd,
   output logic                         freq_sel,
   output logic [SSC_W-1:0]             ssc_code,
   output logic [3:0]                   ssc_quarters,
   output logic                         ssc_center,
   output logic                         freq_changed
);
   if (SEL_W < 2) begin : g_bad_selw
      $error("preset_pin_selector: SEL_W must be at least 2");
   end

   logic [SEL_W-1:0] pins_s, idx;
   logic             p_y1_sel, p_fs, p_y23_sel;
   logic [SSC_W-1:0] p_ssc;
   logic [1:0]       d_y1, d_y23;
   logic             d_pd;

   pps_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(sel_pins), .q_sync(pins_s));

   // S1..S(n-1) read as zero while they carry the serial bus (R7)
   assign idx = bus_mode ? {{(SEL_W-1){1'b0}}, pins_s[0]} : pins_s;

   pps_preset_mux #(.SEL_W(SEL_W)) u_mux (
      .idx(idx), .y1_sel_tbl(y1_sel_tbl), .fs_tbl(fs_tbl), .ssc_tbl(ssc_tbl),
      .y23_sel_tbl(y23_sel_tbl), .y1_sel(p_y1_sel), .fs(p_fs), .ssc(p_ssc),
      .y23_sel(p_y23_sel));

   pps_state_decode u_dec (
      .y1_sel(p_y1_sel), .y23_sel(p_y23_sel), .y1_def0(y1_def0), .y1_def1(y1_def1),
      .y23_def0(y23_def0), .y23_def1(y23_def1), .global_pd(global_pd),
      .y1_mode(d_y1), .y23_mode(d_y23), .pll_pd(d_pd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y1_mode      <= DEF_HIZ;
         y23_mode     <= DEF_HIZ;
         pll_pd       <= 1'b1;
         freq_sel     <= 1'b0;
         ssc_code     <= '0;
         ssc_quarters <= '0;
         ssc_center   <= 1'b0;
         freq_changed <= 1'b0;
      end else begin
         y1_mode      <= d_y1;
         y23_mode     <= d_y23;
         pll_pd       <= d_pd;
         freq_sel     <= p_fs;
         ssc_code     <= p_ssc;
         ssc_quarters <= spread_quarters(p_ssc);
         ssc_center   <= spread_center;
         freq_changed <= (p_fs != freq_sel);
      end
   end

   assert_pd_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
      global_pd |=> (pll_pd && y1_mode == DEF_HIZ && y23_mode == DEF_HIZ));

   assert_y1_mode_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      y1_mode != DEF_PWRDN);

   assert_y23_mode_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      y23_mode != DEF_PWRDN);

   assert_freq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      freq_changed |-> (freq_sel != $past(freq_sel)));

   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      freq_changed |=> (!freq_changed || freq_sel != $past(freq_sel)));

   assert_spread_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ssc_code == '0) == (ssc_quarters == 4'd0));
endmodule

// File: tb/preset_pin_selector_tb_top.sv
module preset_pin_selector_tb_top;
   import pps_pkg::*;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst_n = 0;
   logic [2:0] sel_pins = 0;
   logic bus_mode = 0, global_pd = 0, spread_center = 0;
   logic [7:0] y1_sel_tbl = 0, fs_tbl = 0, y23_sel_tbl = 0;
   logic [23:0] ssc_tbl = 0;
   logic [1:0] y1_def0 = 1, y1_def1 = 3, y23_def0 = 1, y23_def1 = 3;
   logic [1:0] y1_mode, y23_mode;
   logic pll_pd, freq_sel, ssc_center, freq_changed;
   logic [2:0] ssc_code;
   logic [3:0] ssc_quarters;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   preset_pin_selector dut_i (.*);

   // expected values from the requirements
   logic [1:0] e_y1, e_y23;
   logic e_pd, e_fs;
   logic [2:0] e_ssc;
   logic [3:0] e_q;

   task automatic model(input logic [2:0] pins);
      logic [2:0] i;
      logic [1:0] a, b;
      logic pd;
      i = bus_mode ? {2'b00, pins[0]} : pins;
      a = y1_sel_tbl[i] ? y1_def1 : y1_def0;
      b = y23_sel_tbl[i] ? y23_def1 : y23_def0;
      pd = global_pd || a == 2'b00 || b == 2'b00;
      e_pd = pd;
      e_y1 = pd ? 2'b01 : a;
      e_y23 = pd ? 2'b01 : b;
      e_fs = fs_tbl[i];
      e_ssc = ssc_tbl[3*i +: 3];
      e_q = (e_ssc == 3'd7) ? 4'd8 : {1'b0, e_ssc};
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic [2:0] pins);
      model(pins);
      chk({tag, " R3 y1_mode"}, {6'd0, y1_mode}, {6'd0, e_y1});
      chk({tag, " R3 y23_mode"}, {6'd0, y23_mode}, {6'd0, e_y23});
      chk({tag, " R4 pll_pd"}, {7'd0, pll_pd}, {7'd0, e_pd});
      chk({tag, " R5 freq_sel"}, {7'd0, freq_sel}, {7'd0, e_fs});
      chk({tag, " R6 ssc_code"}, {5'd0, ssc_code}, {5'd0, e_ssc});
      chk({tag, " R6 ssc_quarters"}, {4'd0, ssc_quarters}, {4'd0, e_q});
      chk({tag, " R6 ssc_center"}, {7'd0, ssc_center}, {7'd0, spread_center});
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // R1 R2 R9: step pins, check at third edge with pulse, then pulse gone
   task automatic step_pins(input string tag, input logic [2:0] np);
      logic prev_fs;
      model(sel_pins);
      prev_fs = e_fs;
      sel_pins = np;
      cyc(2);
      model(sel_pins);
      chk({tag, " R2 not yet"}, {7'd0, freq_sel}, {7'd0, prev_fs});
      cyc(1);
      chk_all({tag, " R1"}, np);
      chk({tag, " R9 pulse"}, {7'd0, freq_changed}, {7'd0, e_fs != prev_fs});
      cyc(1);
      chk({tag, " R9 pulse end"}, {7'd0, freq_changed}, 8'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 y1", {6'd0, y1_mode}, 8'h01);
      chk("R10 y23", {6'd0, y23_mode}, 8'h01);
      chk("R10 pd", {7'd0, pll_pd}, 8'h01);
      chk("R10 rest", {freq_sel, ssc_code, ssc_center, freq_changed, 2'b00}, 8'h00);
      chk("R10 quarters", {4'd0, ssc_quarters}, 8'h00);

      // R11 defaults from package
      chk("R11 def0", {6'd0, DFLT_DEF0}, 8'h01);
      chk("R11 def1", {6'd0, DFLT_DEF1}, 8'h03);
      chk("R11 seltbl", DFLT_SELTBL, 8'h02);
      y1_sel_tbl = 8'b0000_0010; y23_sel_tbl = 8'b0000_0010;
      y1_def0 = 2'b01; y1_def1 = 2'b11; y23_def0 = 2'b01; y23_def1 = 2'b11;
      bus_mode = 1;
      rst_n = 1;
      cyc(4);
      chk("R11 s0=0 y1 hiz", {6'd0, y1_mode}, 8'h01);
      chk("R11 s0=0 y23 hiz", {6'd0, y23_mode}, 8'h01);
      sel_pins = 3'b001; cyc(3);
      chk("R11 s0=1 y1 on", {6'd0, y1_mode}, 8'h03);
      chk("R11 s0=1 y23 on", {6'd0, y23_mode}, 8'h03);

      // R7 sweep with bus mode on and off, distinct table
      fs_tbl = 8'b1010_0110; ssc_tbl = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0};
      y1_sel_tbl = 8'b1100_1010; y23_sel_tbl = 8'b0110_0101;
      y1_def0 = 2'b10; y1_def1 = 2'b11; y23_def0 = 2'b11; y23_def1 = 2'b10;
      spread_center = 1;
      for (int bm = 0; bm < 2; bm++) begin
         bus_mode = bm[0];
         cyc(5);
         for (int p = 0; p < 8; p++) step_pins(bm ? "R7 bus" : "R1 sweep", p[2:0]);
      end

      // R4 definition 00 powers down, on Y1 and on Y2/Y3
      bus_mode = 0; y1_def1 = 2'b00; cyc(4);
      step_pins("R4 y1 pwrdn", 3'b001);
      y1_def1 = 2'b11; y23_def0 = 2'b00; cyc(4);
      step_pins("R4 y23 pwrdn", 3'b000);
      y23_def0 = 2'b11; cyc(4);

      // R8 global power-down override and release
      step_pins("R8 setup", 3'b011);
      global_pd = 1; cyc(1);
      chk_all("R8 forced", 3'b011);
      chk("R8 pd", {7'd0, pll_pd}, 8'h01);
      global_pd = 0; cyc(1);
      chk_all("R8 released", 3'b011);

      // constrained random
      for (int it = 0; it < 300; it++) begin
         y1_sel_tbl = 8'($urandom); fs_tbl = 8'($urandom);
         y23_sel_tbl = 8'($urandom); ssc_tbl = 24'($urandom);
         y1_def0 = 2'($urandom); y1_def1 = 2'($urandom);
         y23_def0 = 2'($urandom); y23_def1 = 2'($urandom);
         spread_center = 1'($urandom);
         bus_mode = ($urandom % 4) == 0;
         global_pd = ($urandom % 8) == 0;
         cyc(1);
         chk_all("R2 config edge", sel_pins);
         cyc(4);
         step_pins("rand", 3'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule